// File: doc/BRIEF.md
# Audio Subcarrier FM/AM Modulator

This block turns a stream of signed 20-bit audio samples, delivered at 64 kHz with a one-cycle valid strobe, into a signed 12-bit modulated carrier at one sample per clock. The clock is 49.152 MHz. Each accepted sample first passes through a first-order pre-emphasis filter. The filter either passes the sample straight through or runs a recursive section with one of three coefficient sets supplied as register values. The emphasized value is then clipped to a symmetric full-scale range and held until the next sample arrives.

In FM mode the clipped value is scaled to one of four peak deviations and added to the carrier tuning word. The sum then advances a 32-bit phase accumulator that drives a quarter-wave sine table. In AM mode the oscillator runs at the tuning word alone, and the clipped value sets the envelope instead. Full negative scale gives zero envelope and full positive scale gives full envelope. A level input scales the final sample. The output is meant to be summed with other carriers and with video further down the chain.

Top module: `audio_subcarrier_mod`

## Requirements
- R1: `rst_ni` low (asynchronous, active-low) clears the filter state, the phase accumulator and the output register. `carrier_o` reads 0 for as long as `rst_ni` is low.
- R2: `audio_i` is taken only on a clock edge where `audio_valid_i` is 1. With `audio_valid_i` at 0 the emphasized value and the filter state hold, whatever `audio_i` does.
- R3: With `emph_mode_i` = 0 the filter is bypassed, and the emphasized value equals the accepted sample sign-extended to 24 bits.
- R4: With `emph_mode_i` = k (1..3) the emphasized value is y = sat24((b0·x + b1·xprev + a1·yprev) >>> 14). Here xprev and yprev are the previous accepted sample and the previous emphasized value, and sat24 saturates to [-2^23, 2^23-1]. Coefficient set k sits in `emph_coef_i[48k-48 +: 48]`, with b0 in bits [15:0], b1 in [31:16] and a1 in [47:32] of that slice. Each coefficient is a signed Q2.14 value.
- R5: The modulating value is the emphasized value clipped symmetrically to [-(2^19-1), 2^19-1], so it never wraps and never reaches -2^19.
- R6: `dev_sel_i` values 0, 1, 2 and 3 select peak deviations of 50, 75, 100 and 125 kHz. The deviation step is dev = (clip·S) >>> 19, where S = floor(f_dev·2^32 / 49152000).
- R7: In FM mode (`am_mode_i` = 0) the phase accumulator starts at 0 after reset and adds `tune_i` + dev every cycle, modulo 2^32. The sine value is computed from p = phase[31:20] as round(2047·sin(2π(p+0.5)/4096)), rounding half away from zero.
- R8: In AM mode (`am_mode_i` = 1) the phase step is `tune_i` alone. The shaped value is (sine·(clip + 2^19)) >>> 20.
- R9: `carrier_o` = (shaped·`level_i`) >>> 12, with `level_i` unsigned. A `level_i` of 0 gives an output of 0.
- R10: On every clock edge `carrier_o` is loaded from the phase, emphasized value and configuration present before that edge. The emphasized value changes on the edge where `audio_valid_i` is 1, and the phase advances on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| audio_i | input | 20 | Signed audio sample |
| audio_valid_i | input | 1 | Audio sample strobe |
| emph_mode_i | input | 2 | 0 = bypass, 1..3 = coefficient set |
| emph_coef_i | input | 144 | Three packed coefficient sets (b0, b1, a1) |
| dev_sel_i | input | 2 | Peak deviation select |
| am_mode_i | input | 1 | 1 = amplitude modulation |
| tune_i | input | 32 | Carrier phase step per clock |
| level_i | input | 12 | Unsigned output level |
| carrier_o | output | 12 | Signed modulated carrier sample |

## Verification
The bench drives full-scale samples of both signs, so a clip that lets -2^19 through or wraps on overflow shows up as a large frequency or envelope error. It sweeps all four deviation selects and all three coefficient sets, including a set whose gain pushes the filter into clipping. A swapped coefficient field, a wrong deviation step or a missing saturation would therefore shift the phase trajectory. It runs tuning words close to 2^32 to catch a faulty wrap. It also changes `audio_i` without the strobe, so a design that samples on every edge would move the carrier. The AM runs include the zero-envelope extreme, and the level runs include zero, reset is applied mid-run, and every output is checked cycle-exact, so an added or missing pipeline register fails at once.

// File: rtl/subcar_pkg.sv
`timescale 1ns/1ps
package subcar_pkg;
  localparam int unsigned AUD_W   = 20;
  localparam int unsigned EMPH_W  = 24;
  localparam int unsigned COEF_W  = 16;
  localparam int unsigned COEF_FR = 14;
  localparam int unsigned PHASE_W = 32;
  localparam int unsigned LUT_AW  = 10;
  localparam int unsigned OUT_W   = 12;
  localparam int unsigned LVL_W   = 12;
  localparam int unsigned MODE_W  = 2;
  localparam int unsigned NSET    = (1 << MODE_W) - 1;
  localparam longint unsigned FS_HZ = 64'd49152000;
  localparam real PI_R = 3.141592653589793;

  // phase step for the peak deviation picked by sel (50 kHz + 25 kHz per step)
  function automatic logic [PHASE_W-1:0] dev_step(input int unsigned sel);
    longint unsigned hz;
    hz = 64'(50000 + 25000 * sel);
    return PHASE_W'((hz << PHASE_W) / FS_HZ);
  endfunction

  // quarter-wave entry, sampled at bin centres
  function automatic logic [OUT_W-2:0] quarter_sine(input int idx);
    real ang;
    real amp;
    amp = real'((1 << (OUT_W - 1)) - 1);
    ang = (real'(idx) + 0.5) * PI_R / real'(2 * (1 << LUT_AW));
    return (OUT_W-1)'($rtoi(amp * $sin(ang) + 0.5));
  endfunction
endpackage

// File: rtl/subcar_emph.sv
`timescale 1ns/1ps
module subcar_emph import subcar_pkg::*; #(
  parameter int unsigned AW = AUD_W,
  parameter int unsigned EW = EMPH_W,
  parameter int unsigned CW = COEF_W,
  parameter int unsigned CF = COEF_FR
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [AW-1:0]       sample_i,
  input  logic [MODE_W-1:0]          mode_i,
  input  logic [NSET*3*CW-1:0]       coef_i,
  output logic signed [EW-1:0]       emph_o
);
  localparam int unsigned ACC_W = CW + EW + 4;
  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((longint'(1) << (EW - 1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_MIN = -ACC_W'(longint'(1) << (EW - 1));

  logic signed [CW-1:0] b0_set [NSET];
  logic signed [CW-1:0] b1_set [NSET];
  logic signed [CW-1:0] a1_set [NSET];

  for (genvar s = 0; s < NSET; s++) begin : g_set
    assign b0_set[s] = coef_i[s*3*CW      +: CW];
    assign b1_set[s] = coef_i[s*3*CW + CW +: CW];
    assign a1_set[s] = coef_i[s*3*CW+2*CW +: CW];
  end

  logic signed [AW-1:0] x_prev_q;
  logic signed [EW-1:0] y_q;
  logic signed [EW-1:0] y_next;
  logic signed [EW-1:0] sample_ext;
  logic signed [ACC_W-1:0] acc, acc_sh;

  assign sample_ext = EW'(sample_i);

  always_comb begin
    logic signed [ACC_W-1:0] b0_e, b1_e, a1_e;
    logic [MODE_W-1:0] sel;
    sel  = mode_i - MODE_W'(1);
    b0_e = ACC_W'(b0_set[sel]);
    b1_e = ACC_W'(b1_set[sel]);
    a1_e = ACC_W'(a1_set[sel]);
    acc  = b0_e * ACC_W'(sample_i) + b1_e * ACC_W'(x_prev_q) + a1_e * ACC_W'(y_q);
    acc_sh = acc >>> CF;
    if (mode_i == '0)        y_next = sample_ext;
    else if (acc_sh > Y_MAX) y_next = EW'(Y_MAX);
    else if (acc_sh < Y_MIN) y_next = EW'(Y_MIN);
    else                     y_next = EW'(acc_sh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_prev_q <= '0;
      y_q      <= '0;
    end else if (valid_i) begin
      x_prev_q <= sample_i;
      y_q      <= y_next;
    end
  end

  assign emph_o = y_q;

  assert_flat_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == '0) |=> emph_o == $past(sample_ext));

  assert_hold_no_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(emph_o));
endmodule

// File: rtl/subcar_devclip.sv
`timescale 1ns/1ps
module subcar_devclip import subcar_pkg::*; #(
  parameter int unsigned AW = AUD_W,
  parameter int unsigned EW = EMPH_W,
  parameter int unsigned PW = PHASE_W
) (
  input  logic signed [EW-1:0] emph_i,
  input  logic [1:0]           dev_sel_i,
  output logic signed [AW-1:0] mod_o,
  output logic signed [PW-1:0] dev_o
);
  localparam int unsigned PROD_W = AW + PW + 2;
  localparam logic signed [EW-1:0] CLIP_HI = EW'((longint'(1) << (AW - 1)) - 1);
  localparam logic signed [EW-1:0] CLIP_LO = -CLIP_HI;

  logic [PW-1:0] steps [4];
  for (genvar d = 0; d < 4; d++) begin : g_step
    localparam logic [PW-1:0] STEP = dev_step(d);
    assign steps[d] = STEP;
  end

  logic signed [PROD_W-1:0] prod;

  always_comb begin
    if (emph_i > CLIP_HI)      mod_o = AW'(CLIP_HI);
    else if (emph_i < CLIP_LO) mod_o = AW'(CLIP_LO);
    else                       mod_o = AW'(emph_i);
    prod  = PROD_W'(mod_o) * $signed(PROD_W'(steps[dev_sel_i]));
    dev_o = PW'(prod >>> (AW - 1));
  end

  always_comb begin
    assert_clip_symmetric_R5: assert (mod_o != {1'b1, {(AW-1){1'b0}}});
  end
endmodule

// File: rtl/subcar_nco.sv
`timescale 1ns/1ps
module subcar_nco import subcar_pkg::*; #(
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned LA = LUT_AW,
  parameter int unsigned OW = OUT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PW-1:0]        inc_i,
  output logic signed [OW-1:0] sine_o
);
  localparam int unsigned QN = 1 << LA;

  logic [OW-2:0] lut [QN];
  for (genvar g = 0; g < QN; g++) begin : g_lut
    localparam logic [OW-2:0] QV = quarter_sine(g);
    assign lut[g] = QV;
  end

  logic [PW-1:0] phase_q;
  logic [LA+1:0] top;
  logic [LA-1:0] addr;
  logic [OW-2:0] mag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + inc_i;
  end

  // quadrant bit 0 mirrors the address, bit 1 negates
  always_comb begin
    top    = phase_q[PW-1 -: LA+2];
    addr   = top[LA] ? ~top[LA-1:0] : top[LA-1:0];
    mag    = lut[addr];
    sine_o = top[LA+1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/audio_subcarrier_mod.sv
`timescale 1ns/1ps
module audio_subcarrier_mod import subcar_pkg::*; #(
  parameter int unsigned AW = AUD_W,
  parameter int unsigned EW = EMPH_W,
  parameter int unsigned CW = COEF_W,
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned OW = OUT_W,
  parameter int unsigned LW = LVL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [AW-1:0]    audio_i,
  input  logic                    audio_valid_i,
  input  logic [MODE_W-1:0]       emph_mode_i,
  input  logic [NSET*3*CW-1:0]    emph_coef_i,
  input  logic [1:0]              dev_sel_i,
  input  logic                    am_mode_i,
  input  logic [PW-1:0]           tune_i,
  input  logic [LW-1:0]           level_i,
  output logic signed [OW-1:0]    carrier_o
);
  localparam int unsigned ENV_W = AW + 1;
  localparam int unsigned AMP_W = OW + ENV_W + 1;
  localparam int unsigned LVP_W = OW + LW + 2;

  logic signed [EW-1:0] emph;
  logic signed [AW-1:0] mod;
  logic signed [PW-1:0] dev;
  logic signed [OW-1:0] sine;
  logic [PW-1:0]        inc;
  logic signed [OW-1:0] shaped;
  logic signed [OW-1:0] out_d;
  logic signed [OW-1:0] out_q;

  subcar_emph #(.AW(AW), .EW(EW), .CW(CW), .CF(COEF_FR)) i_emph (
    .clk_i, .rst_ni, .valid_i(audio_valid_i), .sample_i(audio_i),
    .mode_i(emph_mode_i), .coef_i(emph_coef_i), .emph_o(emph)
  );

  subcar_devclip #(.AW(AW), .EW(EW), .PW(PW)) i_devclip (
    .emph_i(emph), .dev_sel_i, .mod_o(mod), .dev_o(dev)
  );

  assign inc = tune_i + (am_mode_i ? '0 : PW'(dev));

  subcar_nco #(.PW(PW), .LA(LUT_AW), .OW(OW)) i_nco (
    .clk_i, .rst_ni, .inc_i(inc), .sine_o(sine)
  );

  always_comb begin
    logic signed [AMP_W-1:0] env, am_prod;
    logic signed [LVP_W-1:0] lv_prod;
    env     = AMP_W'(mod) + AMP_W'(longint'(1) << (AW - 1));
    am_prod = AMP_W'(sine) * env;
    shaped  = am_mode_i ? OW'(am_prod >>> AW) : sine;
    lv_prod = LVP_W'(shaped) * $signed(LVP_W'(level_i));
    out_d   = OW'(lv_prod >>> LW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign carrier_o = out_q;

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> carrier_o == '0);

  assert_level_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i == '0 |=> carrier_o == '0);
endmodule

// File: tb/test_audio_subcarrier_mod.sv
`timescale 1ns/1ps
module test_audio_subcarrier_mod;
  localparam real PI = 3.141592653589793;
  localparam int  WD_CYCLES = 100000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic signed [19:0] audio;
  logic               valid;
  logic [1:0]         emode;
  logic [143:0]       coef;
  logic [1:0]         dsel;
  logic               am;
  logic [31:0]        tune;
  logic [11:0]        level;
  logic signed [11:0] carrier;

  audio_subcarrier_mod i_audio_subcarrier_mod (
    .clk_i(clk), .rst_ni(rst_n), .audio_i(audio), .audio_valid_i(valid),
    .emph_mode_i(emode), .emph_coef_i(coef), .dev_sel_i(dsel), .am_mode_i(am),
    .tune_i(tune), .level_i(level), .carrier_o(carrier)
  );

  always #2 clk = ~clk;

  int     vectors = 0;
  int     miscompares = 0;
  bit     done = 1'b0;
  string  cur_req = "R1";
  longint exp_q[$];
  int     cb0[3], cb1[3], ca1[3];

  bit [31:0] m_ph;
  longint    m_x1, m_y1;

  function automatic longint clip_ref(longint v);
    if (v > 524287)  return 524287;
    if (v < -524287) return -524287;
    return v;
  endfunction

  function automatic longint step_ref(int sel);
    return (longint'(50000 + 25000 * sel) << 32) / 64'd49152000;
  endfunction

  function automatic longint sin_ref(int p);
    real v;
    v = 2047.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 4096.0);
    if (v >= 0.0) return longint'($rtoi(v + 0.5));
    return -longint'($rtoi(-v + 0.5));
  endfunction

  // reference model: expected output for the coming edge
  always @(negedge clk) begin
    if (!rst_n) begin
      m_ph = '0; m_x1 = 0; m_y1 = 0;
      exp_q.push_back(0);
    end else begin
      longint m, s, dv, shp, yn, acc;
      m   = clip_ref(m_y1);
      s   = sin_ref(int'(m_ph[31:20]));
      dv  = (m * step_ref(int'(dsel))) >>> 19;
      shp = am ? ((s * (m + 524288)) >>> 20) : s;
      exp_q.push_back((shp * longint'(level)) >>> 12);
      m_ph = 32'(longint'(m_ph) + longint'(tune) + (am ? 0 : dv));
      if (valid) begin
        if (emode == 0) yn = longint'(audio);
        else begin
          acc = longint'(cb0[emode-1]) * longint'(audio) + longint'(cb1[emode-1]) * m_x1
              + longint'(ca1[emode-1]) * m_y1;
          yn = acc >>> 14;
          if (yn > 8388607)  yn = 8388607;
          if (yn < -8388608) yn = -8388608;
        end
        m_x1 = longint'(audio);
        m_y1 = yn;
      end
    end
  end

  // monitor
  always @(posedge clk) begin
    #0.5;
    if (exp_q.size() > 0) begin
      longint e, a, d;
      e = exp_q.pop_front();
      a = longint'(carrier);
      d = a - e;
      vectors++;
      if (d > 2 || d < -2) begin
        miscompares++;
        $display("FAIL %s: carrier_o=%0d expected %0d at %0t", cur_req, a, e, $time);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send(int x, int gap);
    audio = 20'(x); valid = 1'b1;
    step(1);
    valid = 1'b0;
    step(gap);
  endtask

  task automatic set_coef(int k, int b0, int b1, int a1);
    cb0[k] = b0; cb1[k] = b1; ca1[k] = a1;
    coef[k*48 +: 48] = {16'(a1), 16'(b1), 16'(b0)};
  endtask

  initial begin
    rst_n = 1'b0; audio = '0; valid = 1'b0; emode = '0; coef = '0;
    dsel = '0; am = 1'b0; tune = '0; level = 12'd4095;
    for (int k = 0; k < 3; k++) set_coef(k, 0, 0, 0);
    cur_req = "R1";
    step(5);
    rst_n = 1'b1;

    cur_req = "R7";
    tune = 32'h0800_0000;
    step(40);

    cur_req = "R3";
    send(300000, 10);
    send(-200000, 10);
    send(524287, 10);
    cur_req = "R5";
    send(-524288, 12);

    cur_req = "R2";
    audio = 20'sd123456;
    step(8);
    audio = -20'sd400000;
    step(8);

    cur_req = "R6";
    for (int d = 0; d < 4; d++) begin
      dsel = 2'(d);
      send(400000, 16);
      send(-524288, 16);
    end

    cur_req = "R4";
    set_coef(0, 30000, -14000, 6000);
    set_coef(1, 16384, -8000, 12000);
    set_coef(2, 20000, -18000, -3000);
    emode = 2'd1;
    send(500000, 8); send(500000, 8); send(-500000, 8); send(100000, 8);
    cur_req = "R5";
    send(524287, 8); send(-524288, 8);
    cur_req = "R4";
    emode = 2'd2;
    for (int i = 0; i < 6; i++) send((i % 2) ? 350000 : -250000, 6);
    emode = 2'd3;
    for (int i = 0; i < 6; i++) send(90000 * i - 200000, 6);
    emode = 2'd0;

    cur_req = "R8";
    am = 1'b1; tune = 32'h1234_5678;
    send(-524288, 20);
    send(0, 20);
    send(524287, 20);
    send(-262144, 20);
    am = 1'b0;

    cur_req = "R9";
    level = 12'd0;    step(10);
    level = 12'd1000; step(10);
    level = 12'd2048; step(10);
    level = 12'd4095;

    cur_req = "R7";
    tune = 32'hFFFF_FFF0; dsel = 2'd3;
    send(524287, 20);
    tune = 32'h7FFF_FFFF;
    send(-300000, 20);

    cur_req = "R10";
    tune = 32'h0321_0000; dsel = 2'd1; emode = 2'd1;
    for (int i = 0; i < 10; i++) begin
      audio = 20'(i * 97000 - 450000); valid = 1'b1;
      step(1);
    end
    valid = 1'b0; emode = 2'd0;
    step(6);

    cur_req = "R1";
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    tune = 32'h0400_0000;
    send(200000, 20);

    step(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R10: watchdog expired, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule